// File: doc/BRIEF.md
# Option-Configured Watchdog Timer

This block is a watchdog timer whose start-up configuration comes from a small set of nonvolatile option fields. Those fields are sampled once after power-on reset. An active-low hardware-enable field decides whether the watchdog starts on its own. When it is asserted, the idle-run field and the prescaler select are copied into the watchdog control register, and counting begins without any software action. When it is not asserted, the option fields are ignored and the control register keeps its software default. Once the hardware has enabled the watchdog, software cannot turn it off. Software can still kick it and retune the prescaler.

A boot sequencer moves through four named states:

- CAPTURE is the reset state. On the first clock after power-on reset is released, it latches the option fields and moves to APPLY.
- APPLY copies the latched configuration into the control register. It moves to ACTIVE, or to HELD if the system reset is low.
- ACTIVE allows counting. It moves to HELD when the synchronous system reset is low.
- HELD waits out a system reset and returns to APPLY once the system reset is high again.

Because of this sequence, a hardware-enabled watchdog is re-armed with the configuration latched at power-up after every system reset, including the reset that the watchdog itself requests.

A power-of-two prescaler drives a wide counter, and wrapping that counter raises a one-cycle reset request. A sticky flag records that the watchdog caused a reset. The flag is cleared only by power-on reset or by writing 1 to it.

Top module: `wdt_optcfg`

## Requirements
- R1: When `opt_fields[4]` is 0 at power-up, the watchdog runs with no software write. Counting begins on the third clock edge after `por_n` rises, so the first reset request appears after edge 2+P, where P is the period defined in R5.
- R2: When `opt_fields[4]` is 1, the idle and prescaler option fields have no effect, and the control register reads the software default 0x00.
- R3: The option fields are laid out as follows: bit 4 is the active-low hardware enable, bit 3 is idle-run, and bits 2:0 are the prescaler select. The erased value 5'h1F leaves hardware enable off, idle-run on and prescaler code 7.
- R4: The option fields are latched only on the first clock after power-on reset is released. Later changes to them have no effect, even across a system reset. After a system reset, a hardware-enabled configuration is re-applied from the latched copy.
- R5: Prescaler code c divides the clock by 2<<c, from 2 for code 0 up to 256 for code 7. The period P from a clear to the reset request is (2<<c)·2^CNT_W clocks.
- R6: With the idle bit at 0, every clock on which `cpu_idle` is high freezes the count and delays the request by one clock. With the idle bit at 1, `cpu_idle` has no effect.
- R7: While hardware-enabled, a write cannot clear the enable bit, but it does change the prescaler. While hardware enable is off, the enable bit written by software starts and stops the watchdog.
- R8: A `kick` pulse, or a write with bit 1 set, zeroes the prescaler and the counter. Bit 1 always reads back as 0, and no request follows in the cycle after a clear.
- R9: `rst_req` is high for exactly one cycle each time the counter wraps from all ones to zero.
- R10: Bit 6 of the control register is set together with `rst_req`. It survives `sys_rst_n`, is cleared by writing 1 to it, and is cleared by `por_n`.
- R11: The control register is laid out as follows: bit 0 is enable, bit 1 is clear (write only), bits 4:2 are the prescaler code, bit 5 is idle-run and bit 6 is the flag. A system reset restores the default 0x00 but keeps the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| sys_rst_n | input | 1 | Synchronous active-low system reset |
| opt_fields | input | 5 | Nonvolatile option fields (R3 layout) |
| cpu_idle | input | 1 | Processor idle-mode indication |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wdata | input | 7 | Control register write data |
| ctl_rdata | output | 7 | Control register read data |
| kick | input | 1 | Watchdog clear strobe |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Register writes and option loading become visible on `ctl_rdata` on the clock edge that samples them. A boot takes two edges (CAPTURE, then APPLY), and a system reset pulse takes three (HELD, APPLY, ACTIVE). The bench therefore drives at the falling edge and reads only after those edge counts. The reset request is due exactly P edges after the edge that samples a clear, plus one edge for each idle-frozen edge. The bench counts falling edges from the clear and compares that count with the arithmetic period, then checks that the request is low on the following falling edge.

// File: rtl/wdt_optcfg_pkg.sv
package wdt_optcfg_pkg;

    // prescaler select width; divide ratio reaches 2 << (2**PS_W - 1)
    localparam int PS_W      = 3;
    localparam int OPT_W     = PS_W + 2;
    localparam int CTL_W     = PS_W + 4;

    // option field positions
    localparam int OPT_PS_LO   = 0;
    localparam int OPT_IDLE    = PS_W;
    localparam int OPT_HWEN_N  = PS_W + 1;

    // control register positions
    localparam int CTL_EN      = 0;
    localparam int CTL_CLR     = 1;
    localparam int CTL_PS_LO   = 2;
    localparam int CTL_IDLE    = CTL_PS_LO + PS_W;
    localparam int CTL_FLAG    = CTL_IDLE + 1;

    typedef enum logic [1:0] {
        ST_CAPTURE = 2'd0,
        ST_APPLY   = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_HELD    = 2'd3
    } boot_state_e;

    typedef struct packed {
        logic            idle_run;
        logic [PS_W-1:0] ps;
    } wdt_cfg_t;

    localparam wdt_cfg_t CFG_SW_DEFAULT = '{idle_run: 1'b0, ps: '0};

endpackage

// File: rtl/wdt_boot_fsm.sv
module wdt_boot_fsm
    import wdt_optcfg_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic [OPT_W-1:0] opt_fields,
    output wdt_cfg_t         boot_cfg,
    output logic             hw_lock,
    output logic             apply_en,
    output logic             run_ok
);

    boot_state_e state_q;
    boot_state_e state_d;
    logic        capture_en;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_CAPTURE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CAPTURE: state_d = sys_rst_n ? ST_APPLY : ST_HELD;
            ST_APPLY:   state_d = sys_rst_n ? ST_ACTIVE : ST_HELD;
            ST_ACTIVE:  state_d = sys_rst_n ? ST_ACTIVE : ST_HELD;
            ST_HELD:    state_d = sys_rst_n ? ST_APPLY : ST_HELD;
            default:    state_d = ST_CAPTURE;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        capture_en = 1'b0;
        apply_en   = 1'b0;
        run_ok     = 1'b0;
        unique case (state_q)
            ST_CAPTURE: capture_en = 1'b1;
            ST_APPLY:   apply_en   = 1'b1;
            ST_ACTIVE:  run_ok     = 1'b1;
            ST_HELD:    run_ok     = 1'b0;
            default:    run_ok     = 1'b0;
        endcase
    end

    // option fields latched once per power-up
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hw_lock  <= 1'b0;
            boot_cfg <= CFG_SW_DEFAULT;
        end else if (capture_en) begin
            hw_lock           <= ~opt_fields[OPT_HWEN_N];
            boot_cfg.idle_run <= opt_fields[OPT_IDLE];
            boot_cfg.ps       <= opt_fields[OPT_PS_LO +: PS_W];
        end
    end

endmodule

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
    import wdt_optcfg_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic             apply_en,
    input  logic             hw_lock,
    input  wdt_cfg_t         boot_cfg,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    input  logic             wrap_evt,
    output logic             wdt_en,
    output wdt_cfg_t         live_cfg,
    output logic             clr_wr,
    output logic [CTL_W-1:0] rdata
);

    logic flag_q;

    // enable and configuration fields
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            wdt_en   <= 1'b0;
            live_cfg <= CFG_SW_DEFAULT;
        end else if (!sys_rst_n) begin
            wdt_en   <= 1'b0;
            live_cfg <= CFG_SW_DEFAULT;
        end else if (apply_en) begin
            if (hw_lock) begin
                wdt_en   <= 1'b1;
                live_cfg <= boot_cfg;
            end
        end else if (wr_en) begin
            wdt_en            <= wdata[CTL_EN] | hw_lock;
            live_cfg.idle_run <= wdata[CTL_IDLE];
            live_cfg.ps       <= wdata[CTL_PS_LO +: PS_W];
        end
    end

    // sticky flag: set wins over write-one-to-clear, untouched by system reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_q <= 1'b0;
        end else if (wrap_evt) begin
            flag_q <= 1'b1;
        end else if (wr_en && wdata[CTL_FLAG]) begin
            flag_q <= 1'b0;
        end
    end

    assign clr_wr = wr_en & wdata[CTL_CLR] & sys_rst_n;

    always_comb begin
        rdata                     = '0;
        rdata[CTL_EN]             = wdt_en;
        rdata[CTL_PS_LO +: PS_W]  = live_cfg.ps;
        rdata[CTL_IDLE]           = live_cfg.idle_run;
        rdata[CTL_FLAG]           = flag_q;
    end

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            sync_clr,
    input  logic            step,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);

    localparam int DIV_W = 1 << PS_W;

    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] mask;

    // divide ratio is 2 << ps; the top code wraps to an all-ones mask
    assign mask = (DIV_W'(2) << ps) - DIV_W'(1);
    assign tick = step && !sync_clr && ((pre_q & mask) == mask);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pre_q <= '0;
        end else if (sync_clr) begin
            pre_q <= '0;
        end else if (step) begin
            pre_q <= pre_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 15
) (
    input  logic clk,
    input  logic por_n,
    input  logic sync_clr,
    input  logic tick,
    output logic wrap_evt,
    output logic rst_req
);

    logic [CNT_W-1:0] cnt_q;

    assign wrap_evt = tick && !sync_clr && (&cnt_q);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q   <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= wrap_evt;
            if (sync_clr) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/wdt_optcfg.sv
module wdt_optcfg
    import wdt_optcfg_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic [OPT_W-1:0] opt_fields,
    input  logic             cpu_idle,
    input  logic             ctl_wr_en,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             kick,
    output logic             rst_req
);

    wdt_cfg_t boot_cfg;
    wdt_cfg_t live_cfg;
    logic     hw_lock;
    logic     apply_en;
    logic     run_ok;
    logic     wdt_en;
    logic     clr_wr;
    logic     wrap_evt;
    logic     sync_clr;
    logic     step;
    logic     tick;

    wdt_boot_fsm u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .sys_rst_n  (sys_rst_n),
        .opt_fields (opt_fields),
        .boot_cfg   (boot_cfg),
        .hw_lock    (hw_lock),
        .apply_en   (apply_en),
        .run_ok     (run_ok)
    );

    wdt_ctl_reg u_ctl (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .apply_en  (apply_en),
        .hw_lock   (hw_lock),
        .boot_cfg  (boot_cfg),
        .wr_en     (ctl_wr_en),
        .wdata     (ctl_wdata),
        .wrap_evt  (wrap_evt),
        .wdt_en    (wdt_en),
        .live_cfg  (live_cfg),
        .clr_wr    (clr_wr),
        .rdata     (ctl_rdata)
    );

    assign sync_clr = ~sys_rst_n | kick | clr_wr;
    assign step     = run_ok & wdt_en & sys_rst_n & (~cpu_idle | live_cfg.idle_run);

    wdt_prescaler #(.PS_W(PS_W)) u_pre (
        .clk      (clk),
        .por_n    (por_n),
        .sync_clr (sync_clr),
        .step     (step),
        .ps       (live_cfg.ps),
        .tick     (tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .por_n    (por_n),
        .sync_clr (sync_clr),
        .tick     (tick),
        .wrap_evt (wrap_evt),
        .rst_req  (rst_req)
    );

endmodule

// File: rtl/wdt_optcfg_chk.sv
module wdt_optcfg_chk
    import wdt_optcfg_pkg::*;
(
    input logic             clk,
    input logic             por_n,
    input logic             sys_rst_n,
    input logic             cpu_idle,
    input logic             kick,
    input logic             ctl_wr_en,
    input logic [CTL_W-1:0] ctl_rdata,
    input logic             rst_req,
    input logic             hw_lock,
    input logic             run_ok,
    input wdt_cfg_t         boot_cfg
);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);

    a_r10_flag_with_req: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> ctl_rdata[CTL_FLAG]);

    a_r8_clear_quiet: assert property (@(posedge clk) disable iff (!por_n)
        kick |=> !rst_req);

    a_r7_hw_keeps_enable: assert property (@(posedge clk) disable iff (!por_n)
        (hw_lock && run_ok) |-> ctl_rdata[CTL_EN]);

    a_r6_idle_freeze: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_idle && !ctl_rdata[CTL_IDLE] && sys_rst_n && !kick && !ctl_wr_en)
        |=> !rst_req);

    a_r4_latched_once: assert property (@(posedge clk) disable iff (!por_n)
        run_ok |=> $stable({hw_lock, boot_cfg}));

    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!por_n)
        !ctl_rdata[CTL_EN] |=> !rst_req);

endmodule

bind wdt_optcfg wdt_optcfg_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .cpu_idle  (cpu_idle),
    .kick      (kick),
    .ctl_wr_en (ctl_wr_en),
    .ctl_rdata (ctl_rdata),
    .rst_req   (rst_req),
    .hw_lock   (hw_lock),
    .run_ok    (run_ok),
    .boot_cfg  (boot_cfg)
);

// File: tb/wdt_optcfg_tb_top.sv
module wdt_optcfg_tb_top;

    localparam int CNT_W = 4;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       sys_rst_n = 1'b1;
    logic [4:0] opt_fields = 5'h1F;
    logic       cpu_idle = 1'b0;
    logic       ctl_wr_en = 1'b0;
    logic [6:0] ctl_wdata = '0;
    logic [6:0] ctl_rdata;
    logic       kick = 1'b0;
    logic       rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    wdt_optcfg #(.CNT_W(CNT_W)) dut_i (
        .clk        (clk),
        .por_n      (por_n),
        .sys_rst_n  (sys_rst_n),
        .opt_fields (opt_fields),
        .cpu_idle   (cpu_idle),
        .ctl_wr_en  (ctl_wr_en),
        .ctl_wdata  (ctl_wdata),
        .ctl_rdata  (ctl_rdata),
        .kick       (kick),
        .rst_req    (rst_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int period(input int ps);
        return (2 << ps) * (1 << CNT_W);
    endfunction

    task automatic boot(input logic [4:0] opt);
        @(negedge clk);
        por_n = 1'b0;
        opt_fields = opt;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] d);
        @(negedge clk);
        ctl_wr_en = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic sys_pulse();
        @(negedge clk);
        sys_rst_n = 1'b0;
        @(negedge clk);
        sys_rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // clear, then count falling edges until the request; idle window in edges
    task automatic measure(input bit via_wr, input logic [6:0] wd, input int idle_at,
                           input int idle_len, output int n, output bit one_cycle);
        @(negedge clk);
        if (via_wr) begin
            ctl_wr_en = 1'b1;
            ctl_wdata = wd;
        end else begin
            kick = 1'b1;
        end
        @(negedge clk);
        ctl_wr_en = 1'b0;
        kick = 1'b0;
        n = 0;
        cpu_idle = (idle_at == 0 && idle_len > 0);
        one_cycle = 1'b0;
        while (n < 10000) begin
            @(negedge clk);
            n++;
            if (rst_req) break;
            cpu_idle = (n >= idle_at && n < idle_at + idle_len);
        end
        cpu_idle = 1'b0;
        if (n >= 10000) n = -1;
        @(negedge clk);
        one_cycle = !rst_req;
    endtask

    task automatic count_reqs(input int cycles, output int hits);
        hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (rst_req) hits++;
        end
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int hits;
        bit one;
        logic [6:0] exp;

        // R3/R2: erased option fields, hardware enable off
        boot(5'h1F);
        chk(ctl_rdata == 7'h00, "R3 erased default ctl", ctl_rdata, 0);
        chk(rst_req == 1'b0, "R3 reset state req", rst_req, 0);
        boot(5'h1A);
        chk(ctl_rdata == 7'h00, "R2 fields ignored", ctl_rdata, 0);
        count_reqs(300, hits);
        chk(hits == 0, "R2 stays off", hits, 0);

        // R1: start-up latency with no software action
        @(negedge clk);
        por_n = 1'b0;
        opt_fields = 5'b0_1_000;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        n = 0;
        while (n < 1000) begin
            @(negedge clk);
            n++;
            if (rst_req) break;
        end
        chk(n == 2 + period(0), "R1 boot latency", n, 2 + period(0));

        // R1/R5/R6/R9/R10: sweep over idle bit and every prescaler code
        for (int idl = 0; idl < 2; idl++) begin
            for (int ps = 0; ps < 8; ps++) begin
                boot({1'b0, idl[0], ps[2:0]});
                exp = 7'(1 | (ps << 2) | (idl << 5));
                chk(ctl_rdata == exp, "R1 option load", ctl_rdata, exp);
                measure(1'b0, 7'h0, 5, 7, n, one);
                chk(n == period(ps) + (idl != 0 ? 0 : 7),
                    (idl != 0) ? "R5 period idle-run" : "R6 idle freeze",
                    n, period(ps) + (idl != 0 ? 0 : 7));
                chk(one, "R9 one-cycle request", one, 1);
                chk(ctl_rdata[6] == 1'b1, "R10 flag set", ctl_rdata[6], 1);
            end
        end

        // R7: hardware enable survives a disabling write, prescaler changes
        boot(5'b0_1_111);
        wr(7'h00);
        chk(ctl_rdata == 7'h01, "R7 hw keeps enable", ctl_rdata, 1);
        measure(1'b0, 7'h0, 0, 0, n, one);
        chk(n == period(0), "R7 new prescaler", n, period(0));

        // R7: software control when hardware enable is off
        boot(5'h1F);
        wr(7'h05);
        chk(ctl_rdata == 7'h05, "R11 sw write readback", ctl_rdata, 5);
        measure(1'b0, 7'h0, 0, 0, n, one);
        chk(n == period(1), "R7 sw enabled period", n, period(1));
        wr(7'h40);
        wr(7'h00);
        chk(ctl_rdata == 7'h00, "R7 sw disable", ctl_rdata, 0);
        count_reqs(300, hits);
        chk(hits == 0, "R7 sw disabled quiet", hits, 0);

        // R8: clear through the register bit
        wr(7'h05);
        measure(1'b1, 7'h07, 0, 0, n, one);
        chk(n == period(1), "R8 write clear period", n, period(1));
        chk((ctl_rdata & 7'h3F) == 7'h05, "R8 clear reads zero", ctl_rdata & 7'h3F, 5);

        // R10: flag survives system reset, cleared by writing one
        sys_pulse();
        chk(ctl_rdata == 7'h40, "R10 flag kept, R11 defaults", ctl_rdata, 7'h40);
        wr(7'h40);
        chk(ctl_rdata == 7'h00, "R10 flag cleared", ctl_rdata, 0);

        // R4: option fields latched once
        boot(5'b0_1_011);
        chk(ctl_rdata == 7'h2D, "R4 boot load", ctl_rdata, 7'h2D);
        opt_fields = 5'h1F;
        sys_pulse();
        chk(ctl_rdata == 7'h2D, "R4 reapplied latched", ctl_rdata, 7'h2D);
        measure(1'b0, 7'h0, 0, 0, n, one);
        chk(n == period(3), "R4 latched period", n, period(3));
        boot(5'h1F);
        opt_fields = 5'b0_0_000;
        sys_pulse();
        chk(ctl_rdata == 7'h00, "R4 late change ignored", ctl_rdata, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule